// File: doc/BRIEF.md
# MESI snooping coherence controller

This block keeps one processor's small private cache coherent with its peers on a shared snooping bus. Each of its direct-mapped lines holds a coherence state (Modified, Exclusive, Shared or Invalid), an address tag and a one-word payload. The processor issues loads, stores and atomic exchanges through a valid/ready request port and gets a single-cycle response pulse. When a request cannot be served from a line the cache already holds with enough rights, the controller raises a bus request. The request is a read, a read-with-invalidate or an invalidate, and it waits for a grant input that stands in for the external arbiter.

At the same time the controller watches the requests of other caches on the snoop port. It looks up the snooped address, reports in the same cycle whether it holds a copy, and supplies the word when its copy is dirty. It then downgrades or drops its own line at the clock edge. An atomic exchange first makes sure the line is held exclusively. It then keeps the line through a two-cycle read-modify-write window. During that window any snoop to the line gets a retry answer, so the exchange is atomic without holding the bus.

Top module: `mesi_coh_ctrl`

## Requirements
- R1: A load to a line held in any valid state with a matching tag raises no bus request, and its response pulse carries the stored word in the cycle right after acceptance.
- R2: A load miss issues a read (command 1). The line fills Exclusive (state 2) when `bus_shared_in` is low at the winning grant, and Shared (state 1) when it is high. The response carries `bus_fill_data`.
- R3: A store or exchange to an absent line issues read-with-invalidate (command 2), and to a Shared line issues invalidate (command 3). Afterwards the line is Modified (state 3) and later stores to it need no bus.
- R4: A store that hits an Exclusive or Modified line raises no bus request and responds in the cycle after acceptance. The line becomes Modified.
- R5: A snooped read (command 1) that hits a Modified line raises `snp_supply` and `snp_shared` with the line's word on `snp_data`, and leaves the line Shared.
- R6: A snooped read that hits an Exclusive or Shared line raises `snp_shared` without `snp_supply`, and leaves the line Shared.
- R7: A snooped read-with-invalidate or invalidate that hits a valid line invalidates it. A Modified line raises `snp_supply` with its word in that cycle. A snoop whose tag does not match gets no response and changes nothing.
- R8: An exchange returns the line's previous word and stores the new one. It runs only once the line is Exclusive or Modified, and from a held line it responds two cycles after the acceptance edge.
- R9: From acceptance of an exchange until its write has committed, a snoop to that line gets `snp_retry` with neither `snp_shared` nor `snp_supply`, and the line is left unchanged. The first snoop after the response is served normally.
- R10: When a read or read-with-invalidate wins the bus and replaces a Modified line with another tag, `evict_valid` pulses in the grant cycle with the old line's address and word.
- R11: A grant with `bus_retry_in` high changes nothing. The same request stays raised with the same address.
- R12: After reset every line is Invalid, no bus request or response is raised, and `cpu_req_ready` is high while no snoop is present.
- R13: `cpu_req_ready` is low whenever `snp_valid` is high or a request is in progress. Operation codes: 0 load, 1 store, 2 exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_req_op | input | 2 | 0 load, 1 store, 2 exchange |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Store or exchange value |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Load word or exchange old word |
| bus_req_valid | output | 1 | Bus transaction wanted |
| bus_req_cmd | output | 2 | 1 read, 2 read-with-invalidate, 3 invalidate |
| bus_req_addr | output | ADDR_W | Address of the bus transaction |
| bus_grant | input | 1 | Arbiter grant for the raised request |
| bus_retry_in | input | 1 | A peer refused the granted transaction |
| bus_shared_in | input | 1 | A peer holds a copy (read fill) |
| bus_fill_data | input | DATA_W | Word returned for read fills |
| evict_valid | output | 1 | Dirty victim written out this cycle |
| evict_addr | output | ADDR_W | Victim address |
| evict_data | output | DATA_W | Victim word |
| snp_valid | input | 1 | Peer transaction to snoop |
| snp_cmd | input | 2 | Peer command, same encoding as bus_req_cmd |
| snp_addr | input | ADDR_W | Peer transaction address |
| snp_shared | output | 1 | This cache holds a copy |
| snp_supply | output | 1 | This cache supplies its dirty word |
| snp_data | output | DATA_W | Supplied word |
| snp_retry | output | 1 | Line locked by an exchange, retry later |

## Verification
Most wrong internal states show up at the ports only when the affected line is touched again. An undropped snooped line shows up on the next load of that address, which then answers without a bus read. A lost dirty state shows up at the next snoop, where `snp_supply` fails to rise, or at the next store, which issues an unneeded invalidate. A wrong fill state shows up as a silent store where an invalidate was due. The bench therefore follows each state change with an access that exposes it within a few cycles. It also watches the request, response and ready outputs every cycle, and it snoops inside the exchange window to show the lock before and after the write commits.

// File: rtl/mesi_pkg.sv
// Shared types for the coherence controller: line states, bus commands
// and processor operation codes. Encodings are visible at the ports.
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_RDX  = 2'd2,
        BUS_INV  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        F_IDLE   = 2'd0,
        F_BUS    = 2'd1,
        F_XLOCK  = 2'd2,
        F_XWRITE = 2'd3
    } req_fsm_e;

    localparam logic [1:0] OP_LOAD  = 2'd0;
    localparam logic [1:0] OP_STORE = 2'd1;
    localparam logic [1:0] OP_XCHG  = 2'd2;

endpackage

// File: rtl/mesi_line_store.sv
// Direct-mapped line storage: state, tag and one data word per line.
// Two read ports (processor side, snoop side). Processor writes may set
// state, tag and data; snoop writes touch the state only. Assumes the two
// write ports never hit the same line in one cycle; the processor port wins
// if they ever do.
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int TAG_W     = 14,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output line_state_e       rd_a_state,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output line_state_e       rd_b_state,
    output logic [TAG_W-1:0]  rd_b_tag,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              cw_en,
    input  logic [IDX_W-1:0]  cw_idx,
    input  line_state_e       cw_state,
    input  logic [TAG_W-1:0]  cw_tag,
    input  logic              cw_data_en,
    input  logic [DATA_W-1:0] cw_data,
    input  logic              sw_en,
    input  logic [IDX_W-1:0]  sw_idx,
    input  line_state_e       sw_state
);

    line_state_e       st_q  [NUM_LINES];
    logic [TAG_W-1:0]  tag_q [NUM_LINES];
    logic [DATA_W-1:0] dat_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic cw_hit;
        logic sw_hit;
        assign cw_hit = cw_en && (cw_idx == IDX_W'(g));
        assign sw_hit = sw_en && (sw_idx == IDX_W'(g));

        // Per-line state register: processor write first, then snoop write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g] <= ST_I;
            end else if (cw_hit) begin
                st_q[g] <= cw_state;
            end else if (sw_hit) begin
                st_q[g] <= sw_state;
            end
        end

        // Per-line tag and data registers, written from the processor side.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[g] <= '0;
                dat_q[g] <= '0;
            end else if (cw_hit) begin
                tag_q[g] <= cw_tag;
                if (cw_data_en) begin
                    dat_q[g] <= cw_data;
                end
            end
        end
    end

    // Read port muxes.
    assign rd_a_state = st_q[rd_a_idx];
    assign rd_a_tag   = tag_q[rd_a_idx];
    assign rd_a_data  = dat_q[rd_a_idx];
    assign rd_b_state = st_q[rd_b_idx];
    assign rd_b_tag   = tag_q[rd_b_idx];
    assign rd_b_data  = dat_q[rd_b_idx];

endmodule

// File: rtl/mesi_snoop_port.sv
// Snoop responder: decides in the same cycle whether a peer transaction hits
// a local line, whether the line is locked by an exchange (retry), whether a
// dirty word must be supplied, and which state the line takes at the edge.
// Purely combinational; assumes the line store read port is indexed by the
// snoop address.
module mesi_snoop_port
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 14,
    parameter int DATA_W = 32
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic              lock_on_line,
    input  line_state_e       line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data,
    output logic              snp_retry,
    output logic              sw_en,
    output line_state_e       sw_state
);

    logic hit;
    logic serve;

    // Hit detection, lock check and next-state choice.
    always_comb begin
        hit        = snp_valid && (snp_cmd != BUS_NONE) &&
                     (line_state != ST_I) && (line_tag == snp_tag);
        snp_retry  = hit && lock_on_line;
        serve      = hit && !lock_on_line;
        snp_shared = serve;
        snp_supply = serve && (line_state == ST_M);
        snp_data   = line_data;
        sw_en      = serve;
        sw_state   = (snp_cmd == BUS_RD) ? ST_S : ST_I;
    end

endmodule

// File: rtl/mesi_req_fsm.sv
// Processor-side request engine. Serves hits locally, raises one bus
// request for misses and missing rights, fills or upgrades the line on a
// winning grant, and runs exchanges as a locked read cycle followed by a
// write cycle. Assumes bus_grant never coincides with snp_valid (the bus
// carries one transaction at a time).
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic [1:0]        cpu_req_op,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    input  logic              snp_busy,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_grant,
    input  logic              bus_retry_in,
    input  logic              bus_shared_in,
    input  logic [DATA_W-1:0] bus_fill_data,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr,
    output logic [DATA_W-1:0] evict_data,
    output logic [IDX_W-1:0]  lk_idx,
    input  line_state_e       lk_state,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [DATA_W-1:0] lk_data,
    output logic              cw_en,
    output line_state_e       cw_state,
    output logic [TAG_W-1:0]  cw_tag,
    output logic              cw_data_en,
    output logic [DATA_W-1:0] cw_data,
    output logic              lock_active,
    output logic [IDX_W-1:0]  lock_idx
);

    req_fsm_e          fsm_q;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] old_q;
    logic              resp_q;
    logic [DATA_W-1:0] rdata_q;

    logic              idle;
    logic              accept;
    logic [ADDR_W-1:0] cur_addr;
    logic [TAG_W-1:0]  cur_tag;
    logic [1:0]        cur_op;
    logic              hit;
    logic              owned;
    bus_cmd_e          cmd;
    logic              win;

    // Lookup of the current request against the line it maps to.
    always_comb begin
        idle     = (fsm_q == F_IDLE);
        cur_addr = idle ? cpu_req_addr : addr_q;
        cur_op   = idle ? cpu_req_op : op_q;
        lk_idx   = cur_addr[IDX_W-1:0];
        cur_tag  = cur_addr[ADDR_W-1:IDX_W];
        hit      = (lk_state != ST_I) && (lk_tag == cur_tag);
        owned    = hit && ((lk_state == ST_E) || (lk_state == ST_M));
        cpu_req_ready = idle && !snp_busy;
        accept   = cpu_req_valid && cpu_req_ready;
    end

    // Bus command choice, grant qualification and victim write-out.
    always_comb begin
        if (cur_op == OP_LOAD) begin
            cmd = BUS_RD;
        end else if (hit && (lk_state == ST_S)) begin
            cmd = BUS_INV;
        end else begin
            cmd = BUS_RDX;
        end
        bus_req_valid = (fsm_q == F_BUS);
        bus_req_cmd   = cmd;
        bus_req_addr  = addr_q;
        win           = bus_req_valid && bus_grant && !bus_retry_in;
        evict_valid   = win && (cmd != BUS_INV) && (lk_state == ST_M) &&
                        (lk_tag != cur_tag);
        evict_addr    = {lk_tag, lk_idx};
        evict_data    = lk_data;
        lock_active   = (fsm_q == F_XLOCK) || (fsm_q == F_XWRITE);
        lock_idx      = addr_q[IDX_W-1:0];
    end

    // Line writes from the processor side: silent store, fill/upgrade, exchange write.
    always_comb begin
        cw_en      = 1'b0;
        cw_state   = ST_M;
        cw_tag     = cur_tag;
        cw_data_en = 1'b0;
        cw_data    = bus_fill_data;
        unique case (fsm_q)
            F_IDLE: begin
                if (accept && (cur_op == OP_STORE) && owned) begin
                    cw_en      = 1'b1;
                    cw_data_en = 1'b1;
                    cw_data    = cpu_req_wdata;
                end
            end
            F_BUS: begin
                if (win) begin
                    cw_en      = 1'b1;
                    cw_data_en = (cmd != BUS_INV);
                    if (op_q == OP_LOAD) begin
                        cw_state = bus_shared_in ? ST_S : ST_E;
                    end else if (op_q == OP_STORE) begin
                        cw_data_en = 1'b1;
                        cw_data    = wdata_q;
                    end
                end
            end
            F_XWRITE: begin
                cw_en      = 1'b1;
                cw_data_en = 1'b1;
                cw_data    = wdata_q;
            end
            default: ;
        endcase
    end

    // Sequencing of requests and the registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q   <= F_IDLE;
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            old_q   <= '0;
            resp_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            resp_q <= 1'b0;
            unique case (fsm_q)
                F_IDLE: begin
                    if (accept) begin
                        op_q    <= cpu_req_op;
                        addr_q  <= cpu_req_addr;
                        wdata_q <= cpu_req_wdata;
                        if (cpu_req_op == OP_LOAD) begin
                            if (hit) begin
                                resp_q  <= 1'b1;
                                rdata_q <= lk_data;
                            end else begin
                                fsm_q <= F_BUS;
                            end
                        end else if (cpu_req_op == OP_STORE) begin
                            if (owned) begin
                                resp_q  <= 1'b1;
                                rdata_q <= '0;
                            end else begin
                                fsm_q <= F_BUS;
                            end
                        end else begin
                            fsm_q <= owned ? F_XLOCK : F_BUS;
                        end
                    end
                end
                F_BUS: begin
                    if (win) begin
                        if (op_q == OP_LOAD) begin
                            resp_q  <= 1'b1;
                            rdata_q <= bus_fill_data;
                            fsm_q   <= F_IDLE;
                        end else if (op_q == OP_STORE) begin
                            resp_q  <= 1'b1;
                            rdata_q <= '0;
                            fsm_q   <= F_IDLE;
                        end else begin
                            fsm_q <= F_XLOCK;
                        end
                    end
                end
                F_XLOCK: begin
                    old_q <= lk_data;
                    fsm_q <= F_XWRITE;
                end
                F_XWRITE: begin
                    resp_q  <= 1'b1;
                    rdata_q <= old_q;
                    fsm_q   <= F_IDLE;
                end
                default: fsm_q <= F_IDLE;
            endcase
        end
    end

    assign cpu_resp_valid = resp_q;
    assign cpu_resp_rdata = rdata_q;

endmodule

// File: rtl/mesi_coh_ctrl.sv
// Coherence controller for one private direct-mapped cache on a snooping
// bus. Connects the line store, the processor request engine and the snoop
// responder. Assumes NUM_LINES is a power of two, at least 2, and that the
// environment never grants the bus in a cycle carrying a snoop.
module mesi_coh_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_LINES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic [1:0]        cpu_req_op,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_grant,
    input  logic              bus_retry_in,
    input  logic              bus_shared_in,
    input  logic [DATA_W-1:0] bus_fill_data,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr,
    output logic [DATA_W-1:0] evict_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data,
    output logic              snp_retry
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  lk_idx;
    line_state_e       lk_state;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    line_state_e       sn_state;
    logic [TAG_W-1:0]  sn_tag;
    logic [DATA_W-1:0] sn_data;
    logic              cw_en;
    line_state_e       cw_state;
    logic [TAG_W-1:0]  cw_tag;
    logic              cw_data_en;
    logic [DATA_W-1:0] cw_data;
    logic              sw_en;
    line_state_e       sw_state;
    logic              lock_active;
    logic [IDX_W-1:0]  lock_idx;
    logic              lock_on_line;

    assign lock_on_line = lock_active && (lock_idx == snp_addr[IDX_W-1:0]);

    mesi_line_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (lk_idx),
        .rd_a_state (lk_state),
        .rd_a_tag   (lk_tag),
        .rd_a_data  (lk_data),
        .rd_b_idx   (snp_addr[IDX_W-1:0]),
        .rd_b_state (sn_state),
        .rd_b_tag   (sn_tag),
        .rd_b_data  (sn_data),
        .cw_en      (cw_en),
        .cw_idx     (lk_idx),
        .cw_state   (cw_state),
        .cw_tag     (cw_tag),
        .cw_data_en (cw_data_en),
        .cw_data    (cw_data),
        .sw_en      (sw_en),
        .sw_idx     (snp_addr[IDX_W-1:0]),
        .sw_state   (sw_state)
    );

    mesi_req_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_req (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_ready  (cpu_req_ready),
        .cpu_req_op     (cpu_req_op),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_wdata  (cpu_req_wdata),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_rdata (cpu_resp_rdata),
        .snp_busy       (snp_valid),
        .bus_req_valid  (bus_req_valid),
        .bus_req_cmd    (bus_req_cmd),
        .bus_req_addr   (bus_req_addr),
        .bus_grant      (bus_grant),
        .bus_retry_in   (bus_retry_in),
        .bus_shared_in  (bus_shared_in),
        .bus_fill_data  (bus_fill_data),
        .evict_valid    (evict_valid),
        .evict_addr     (evict_addr),
        .evict_data     (evict_data),
        .lk_idx         (lk_idx),
        .lk_state       (lk_state),
        .lk_tag         (lk_tag),
        .lk_data        (lk_data),
        .cw_en          (cw_en),
        .cw_state       (cw_state),
        .cw_tag         (cw_tag),
        .cw_data_en     (cw_data_en),
        .cw_data        (cw_data),
        .lock_active    (lock_active),
        .lock_idx       (lock_idx)
    );

    mesi_snoop_port #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_snoop (
        .snp_valid    (snp_valid),
        .snp_cmd      (snp_cmd),
        .snp_tag      (snp_addr[ADDR_W-1:IDX_W]),
        .lock_on_line (lock_on_line),
        .line_state   (sn_state),
        .line_tag     (sn_tag),
        .line_data    (sn_data),
        .snp_shared   (snp_shared),
        .snp_supply   (snp_supply),
        .snp_data     (snp_data),
        .snp_retry    (snp_retry),
        .sw_en        (sw_en),
        .sw_state     (sw_state)
    );

endmodule

// File: rtl/mesi_coh_checker.sv
// Port-level protocol checks for the coherence controller, bound to every
// instance of the top module.
module mesi_coh_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_resp_valid,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_grant,
    input logic              bus_retry_in,
    input logic              evict_valid,
    input logic              snp_valid,
    input logic              snp_shared,
    input logic              snp_supply,
    input logic              snp_retry
);

    // A raised bus request always carries one of the three real commands.
    assert_cmd_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (bus_req_cmd != 2'd0));

    // A retried snoop reports neither a copy nor supplied data.
    assert_retry_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_retry |-> (!snp_supply && !snp_shared));

    // Retry only answers a live snoop, and only while the lock holds off new requests.
    assert_retry_needs_snoop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_retry |-> (snp_valid && !cpu_req_ready));

    // Supplying data implies a live snoop that also reports the copy.
    assert_supply_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_valid && snp_shared));

    // Victim write-out happens only on a winning grant.
    assert_evict_at_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (bus_req_valid && bus_grant && !bus_retry_in));

    // A refused grant keeps the same request raised.
    assert_retry_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_grant && bus_retry_in) |=>
            (bus_req_valid && $stable(bus_req_addr)));

    // No acceptance while a snoop is present or a bus request is pending.
    assert_ready_blocked_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid || bus_req_valid) |-> !cpu_req_ready);

    // Leaving reset, nothing is outstanding.
    assert_reset_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!bus_req_valid && !cpu_resp_valid));

    // An accepted request never responds in the acceptance cycle itself.
    assert_resp_registered_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |-> !cpu_resp_valid);

endmodule

bind mesi_coh_ctrl mesi_coh_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/mesi_coh_ctrl_tb.sv
// Self-checking bench: a behavioural line model (state, tag, word per index)
// predicts every bus command, response, eviction and snoop answer.
module mesi_coh_ctrl_tb;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_ready;
    logic [1:0]    cpu_req_op = 2'd0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_resp_valid;
    logic [DW-1:0] cpu_resp_rdata;
    logic          bus_req_valid;
    logic [1:0]    bus_req_cmd;
    logic [AW-1:0] bus_req_addr;
    logic          bus_grant = 1'b0;
    logic          bus_retry_in = 1'b0;
    logic          bus_shared_in = 1'b0;
    logic [DW-1:0] bus_fill_data = '0;
    logic          evict_valid;
    logic [AW-1:0] evict_addr;
    logic [DW-1:0] evict_data;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_shared;
    logic          snp_supply;
    logic [DW-1:0] snp_data;
    logic          snp_retry;

    int n_tests = 0;
    int n_fail  = 0;
    bit op_active = 1'b0;

    // Reference model: 0 I, 1 S, 2 E, 3 M
    int            ref_st  [NL];
    logic [13:0]   ref_tag [NL];
    logic [DW-1:0] ref_dat [NL];

    always #2 clk = ~clk;

    mesi_coh_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_LINES(NL)) u_dut (.*);

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Idle-time comparison on every clock.
    always @(posedge clk) begin
        #1;
        if (rst_n && !op_active) begin
            chk(!bus_req_valid && !cpu_resp_valid, "R12", "quiet when idle",
                {bus_req_valid, cpu_resp_valid}, 0);
            chk(cpu_req_ready == !snp_valid, "R13", "ready vs snoop",
                cpu_req_ready, !snp_valid);
        end
    end

    task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic shr,
                         input logic [DW-1:0] fill, input bit retry_first,
                         input string rq);
        int idx;
        logic [13:0] tg;
        bit hit;
        bit own;
        int exp_cmd;
        bit exp_ev;
        logic [DW-1:0] exp_rd;
        int seen_cmd;
        bit got;
        bit ev_seen;
        int waited;
        bit rf;
        idx = int'(a[1:0]);
        tg  = a[15:2];
        hit = (ref_st[idx] != 0) && (ref_tag[idx] == tg);
        own = hit && (ref_st[idx] >= 2);
        if (op == 2'd0) exp_cmd = hit ? 0 : 1;
        else if (own) exp_cmd = 0;
        else if (hit && ref_st[idx] == 1) exp_cmd = 3;
        else exp_cmd = 2;
        exp_ev = (exp_cmd == 1 || exp_cmd == 2) && ref_st[idx] == 3 && ref_tag[idx] != tg;
        exp_rd = hit ? ref_dat[idx] : fill;
        seen_cmd = 0; got = 0; ev_seen = 0; waited = -1; rf = retry_first;
        op_active = 1'b1;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_op = op; cpu_req_addr = a; cpu_req_wdata = wd;
        #1 chk(cpu_req_ready == 1'b1, "R13", "ready at request", cpu_req_ready, 1);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        for (int c = 0; c < 30 && !got; c++) begin
            if (cpu_resp_valid) begin
                got = 1; waited = c;
                if (op != 2'd1)
                    chk(cpu_resp_rdata == exp_rd, rq, "response word", cpu_resp_rdata, exp_rd);
            end else if (bus_req_valid) begin
                seen_cmd = int'(bus_req_cmd);
                chk(bus_req_addr == a, rq, "bus address", bus_req_addr, a);
                bus_grant = 1'b1; bus_shared_in = shr; bus_fill_data = fill; bus_retry_in = rf;
                #1;
                if (rf) chk(!evict_valid, "R11", "no evict on refused grant", evict_valid, 0);
                else begin
                    ev_seen = evict_valid;
                    if (evict_valid) begin
                        chk(evict_addr == {ref_tag[idx], a[1:0]}, "R10", "evict address",
                            evict_addr, {ref_tag[idx], a[1:0]});
                        chk(evict_data == ref_dat[idx], "R10", "evict word", evict_data, ref_dat[idx]);
                    end
                end
                @(negedge clk);
                bus_grant = 1'b0; bus_retry_in = 1'b0;
                if (rf) begin
                    chk(bus_req_valid && bus_req_cmd == 2'(exp_cmd), "R11", "request kept after refusal",
                        {bus_req_valid, bus_req_cmd}, {1'b1, 2'(exp_cmd)});
                    rf = 0;
                end
            end else begin
                @(negedge clk);
            end
        end
        chk(got, rq, "response seen", got, 1);
        chk(seen_cmd == exp_cmd, rq, "bus command", seen_cmd, exp_cmd);
        chk(ev_seen == exp_ev, "R10", "eviction pulse", ev_seen, exp_ev);
        if (exp_cmd == 0 && op != 2'd2)
            chk(waited == 0, rq, "hit latency", waited, 0);
        if (exp_cmd == 0 && op == 2'd2)
            chk(waited == 2, "R8", "exchange latency", waited, 2);
        ref_tag[idx] = tg;
        if (op == 2'd0) begin
            if (!hit) begin
                ref_st[idx] = shr ? 1 : 2;
                ref_dat[idx] = fill;
            end
        end else begin
            ref_st[idx] = 3;
            ref_dat[idx] = wd;
        end
        op_active = 1'b0;
    endtask

    task automatic do_snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input string rq);
        int idx;
        bit hit;
        bit dirty;
        idx   = int'(a[1:0]);
        hit   = (ref_st[idx] != 0) && (ref_tag[idx] == a[15:2]);
        dirty = hit && ref_st[idx] == 3;
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
        #1;
        chk(snp_shared == hit, rq, "snoop shared", snp_shared, hit);
        chk(snp_supply == dirty, rq, "snoop supply", snp_supply, dirty);
        chk(!snp_retry, rq, "no retry", snp_retry, 0);
        if (dirty) chk(snp_data == ref_dat[idx], rq, "supplied word", snp_data, ref_dat[idx]);
        @(negedge clk);
        snp_valid = 1'b0;
        if (hit) ref_st[idx] = (cmd == 2'd1) ? 1 : 0;
    endtask

    initial begin
        #(200000 * 4);
        chk(0, "WD", "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) begin
            ref_st[i] = 0; ref_tag[i] = '0; ref_dat[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(cpu_req_ready && !bus_req_valid && !cpu_resp_valid, "R12", "reset outputs",
            {cpu_req_ready, bus_req_valid, cpu_resp_valid}, 3'b100);

        // R2 exclusive fill, R1 hit, R4 silent store, R5 dirty snoop read
        do_op(2'd0, 16'h0010, 0, 1'b0, 32'h11, 0, "R2");
        do_op(2'd0, 16'h0010, 0, 1'b0, 32'h0, 0, "R1");
        do_op(2'd1, 16'h0010, 32'h22, 1'b0, 32'h0, 0, "R4");
        do_snoop(2'd1, 16'h0010, "R5");
        do_op(2'd1, 16'h0010, 32'h33, 1'b0, 32'h0, 0, "R3");   // INV from Shared
        // R2 shared fill, R1 repeated hits, R3 upgrade
        do_op(2'd0, 16'h0021, 0, 1'b1, 32'h44, 0, "R2");
        do_op(2'd0, 16'h0021, 0, 1'b0, 32'h0, 0, "R1");
        do_op(2'd1, 16'h0021, 32'h55, 1'b0, 32'h0, 0, "R3");
        // R6 clean snoop read, R7 invalidating snoops
        do_op(2'd0, 16'h0002, 0, 1'b0, 32'h66, 0, "R2");
        do_snoop(2'd1, 16'h0002, "R6");
        do_snoop(2'd2, 16'h0002, "R7");
        do_op(2'd0, 16'h0002, 0, 1'b0, 32'h67, 0, "R7");
        do_snoop(2'd3, 16'h0021, "R7");
        do_op(2'd0, 16'h0021, 0, 1'b0, 32'h68, 0, "R7");
        do_snoop(2'd1, 16'h0050, "R7");                         // tag mismatch
        // R3 read-with-invalidate, R10 dirty victim
        do_op(2'd1, 16'h0003, 32'h88, 1'b0, 32'h77, 0, "R3");
        do_op(2'd0, 16'h0003, 0, 1'b0, 32'h0, 0, "R4");
        do_op(2'd0, 16'h0013, 0, 1'b0, 32'h99, 0, "R10");

        // R8/R9 exchange on an Exclusive line with snoops inside the window
        op_active = 1'b1;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_op = 2'd2; cpu_req_addr = 16'h0013; cpu_req_wdata = 32'hAB;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 16'h0013;
        #1;
        chk(snp_retry && !snp_shared && !snp_supply, "R9", "retry in locked read",
            {snp_retry, snp_shared, snp_supply}, 3'b100);
        chk(!bus_req_valid, "R8", "no bus for held line", bus_req_valid, 0);
        @(negedge clk);
        snp_cmd = 2'd2;
        #1 chk(snp_retry, "R9", "retry in locked write", snp_retry, 1);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk(cpu_resp_valid, "R8", "exchange response", cpu_resp_valid, 1);
        chk(cpu_resp_rdata == 32'h99, "R8", "exchange old word", cpu_resp_rdata, 32'h99);
        ref_st[3] = 3; ref_dat[3] = 32'hAB;
        op_active = 1'b0;
        do_snoop(2'd1, 16'h0013, "R9");                         // served after commit

        // R8 exchange from a miss, evicting the dirty line at index 0
        do_op(2'd2, 16'h0030, 32'hCD, 1'b0, 32'h5A, 0, "R8");
        do_op(2'd0, 16'h0030, 0, 1'b0, 32'h0, 0, "R8");
        // R8 exchange on a Shared line needs invalidate
        do_op(2'd2, 16'h0013, 32'hEF, 1'b0, 32'h0, 0, "R8");
        // R11 refused grant
        do_op(2'd0, 16'h0041, 0, 1'b1, 32'h42, 1, "R11");

        // R13 request held off by a snoop
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_op = 2'd0; cpu_req_addr = 16'h0002;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 16'h0100;
        #1 chk(!cpu_req_ready, "R13", "ready low under snoop", cpu_req_ready, 0);
        @(negedge clk);
        cpu_req_valid = 1'b0; snp_valid = 1'b0;
        #1 chk(!cpu_resp_valid && !bus_req_valid, "R13", "held-off request ignored",
               {cpu_resp_valid, bus_req_valid}, 0);

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule